// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one host-side I2C master transaction from a single control byte. Software writes the control value. If that value asks for a transfer, the sequencer does the following in order:

- It opens the bus with a start and the 7-bit target address, unless an earlier chained transfer still owns the bus.
- It moves between one and four data bytes. Outgoing bytes come from a small transmit vector. Incoming bytes are placed in a receive vector.
- It either releases the bus with a stop or keeps it for a later chained transfer.

The block does no bit timing of its own. Every bus action goes to a byte-level engine as a command: start with address, write byte, read byte or stop. The engine answers each command with an ack/nack result.

Any nack from the target ends the data phase early. It raises a sticky error flag and an aborted flag. A halt request releases a bus that is being held, without moving any data. The block is busy from the accepted command until a one-cycle completion pulse. That pulse carries the number of bytes that were acknowledged.

Top module: `i2cXferSeq`

## Requirements
- R1: After reset the control readback, error, aborted and bus-held flags are all zero, busy and done are low and no engine command is valid.
- R2: A control write taken while idle is stored and read back with bit 0 (go) forced to zero. Bit 6 (wide-address request) is stored but has no effect: the command address is always the low-address input bits 7:1.
- R3: A start command (opcode 0) with the address and the read bit (control bit 1) is issued only when the bus is not held. Write-byte is opcode 1, read-byte is opcode 2 and stop is opcode 3.
- R4: The byte count is control bits 5:4 plus one. Write byte i is taken from transmit bits 8i+7:8i. Read byte i lands in receive bits 8i+7:8i. Every receive byte is cleared when a transfer begins.
- R5: A nacked start sets the error and aborted flags, and no data command follows. An acked start clears the error flag and marks the bus held.
- R6: A nacked data byte sets error and aborted and ends the data phase. While the error flag is set, a chained transfer on a held bus skips every byte.
- R7: After the data phase a stop is issued if the bus is held and either the repeated-start bit (bit 3) is set or the chain bit (bit 2) is clear. Otherwise the bus stays held.
- R8: A control write with the halt bit (bit 7) while the bus is held issues only a stop and releases the bus. Its completion reports zero bytes and leaves the error and aborted flags unchanged.
- R9: Busy is high from the accepted command until the completion pulse. Control writes made while busy are ignored.
- R10: Done is a single-cycle pulse. The count reported with it equals the number of data bytes the target acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte value |
| lowAddr | input | 8 | Address register; bits 7:1 form the target address |
| txData | input | 32 | Outgoing bytes, byte i at bits 8i+7:8i |
| ctrlRead | output | 8 | Stored control value, go bit reads zero |
| rxData | output | 32 | Received bytes, byte i at bits 8i+7:8i |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| doneCount | output | 3 | Acknowledged byte count, valid with done |
| errFlag | output | 1 | Sticky error flag |
| abortFlag | output | 1 | Transfer aborted flag |
| busHeld | output | 1 | Bus currently owned by this master |
| cmdValid | output | 1 | Engine command valid, held until response |
| cmdOp | output | 2 | Engine opcode |
| cmdAddr | output | 7 | Target address for start |
| cmdRd | output | 1 | Direction bit sent with the address |
| cmdWrByte | output | 8 | Byte for a write command |
| rspValid | input | 1 | Engine response strobe |
| rspNack | input | 1 | Response was a nack |
| rspRdByte | input | 8 | Byte returned by a read command |

## Verification
The hardest case to reach from the ports is a chained transfer that starts while the bus is held and the error flag is already set. Getting there takes a nacked data byte in an earlier transfer that kept the bus, because its chain bit was set and its repeated-start bit was clear. The next transfer must then be issued before any halt. The random stimulus sets the chain bit on about half of the transfers and injects nacks at random byte positions. A directed sequence also builds this case deliberately. Further directed cases cover a halt on a held bus, a write made while busy, and a nacked address.

// File: rtl/i2cSeqPkg.sv
package i2cSeqPkg;
  localparam int CTRL_W      = 8;
  localparam int BIT_GO      = 0;
  localparam int BIT_RD      = 1;
  localparam int BIT_CHAIN   = 2;
  localparam int BIT_RESTART = 3;
  localparam int BIT_CNT_LO  = 4;
  localparam int BIT_WIDE    = 6;
  localparam int BIT_HALT    = 7;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } engOp_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DATA, S_STOP, S_FIN
  } seqState_t;

  typedef struct packed {
    logic acceptCtrl;
    logic beginXfer;
    logic setErr;
    logic clrErr;
    logic setAbort;
    logic setHeld;
    logic clrHeld;
    logic byteOk;
  } seqStrobe_t;
endpackage

// File: rtl/i2cSeqData.sv
module i2cSeqData
  import i2cSeqPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobe_t                  stb,
  input  logic                        busyIn,
  input  logic                        ctrlWrEn,
  input  logic [CTRL_W-1:0]           ctrlWrData,
  input  logic [DATA_W-1:0]           rspRdByte,
  input  logic [MAX_BYTES*DATA_W-1:0] txData,
  output logic [CTRL_W-1:0]           ctrlReg,
  output logic [MAX_BYTES*DATA_W-1:0] rxData,
  output logic [$clog2(MAX_BYTES+1)-1:0] xferCount,
  output logic                        isFinalByte,
  output logic                        errFlag,
  output logic                        abortFlag,
  output logic                        busHeld,
  output logic [DATA_W-1:0]           curTxByte
);
  localparam int IDX_W = $clog2(MAX_BYTES);
  localparam int CNT_W = $clog2(MAX_BYTES+1);

  logic [DATA_W-1:0] txMem [MAX_BYTES];
  logic [DATA_W-1:0] rxMem [MAX_BYTES];
  logic [IDX_W-1:0]  lastIdx;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : gBytes
    assign txMem[g] = txData[g*DATA_W +: DATA_W];
    assign rxData[g*DATA_W +: DATA_W] = rxMem[g];
  end

  assign lastIdx     = ctrlReg[BIT_CNT_LO +: IDX_W];
  assign isFinalByte = (xferCount == CNT_W'(lastIdx));
  assign curTxByte   = txMem[xferCount[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      xferCount <= '0;
      errFlag   <= 1'b0;
      abortFlag <= 1'b0;
      busHeld   <= 1'b0;
      for (int i = 0; i < MAX_BYTES; i++) rxMem[i] <= '0;
    end else begin
      if (stb.acceptCtrl) begin
        ctrlReg   <= ctrlWrData & ~(CTRL_W'(1) << BIT_GO);
        xferCount <= '0;
      end
      if (stb.beginXfer) begin
        abortFlag <= 1'b0;
        for (int i = 0; i < MAX_BYTES; i++) rxMem[i] <= '0;
      end
      if (stb.setErr)      errFlag <= 1'b1;
      else if (stb.clrErr) errFlag <= 1'b0;
      if (stb.setAbort)    abortFlag <= 1'b1;
      if (stb.setHeld)       busHeld <= 1'b1;
      else if (stb.clrHeld)  busHeld <= 1'b0;
      if (stb.byteOk) begin
        xferCount <= xferCount + 1'b1;
        if (ctrlReg[BIT_RD]) rxMem[xferCount[IDX_W-1:0]] <= rspRdByte;
      end
    end
  end

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && ctrlWrEn) |=> $stable(ctrlReg));

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferCount <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/i2cSeqCtrl.sv
module i2cSeqCtrl
  import i2cSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              busHeld,
  input  logic              errFlag,
  input  logic              abortFlag,
  input  logic              isFinalByte,
  input  logic              readDir,
  input  logic              chainBit,
  input  logic              restartBit,
  input  logic              rspValid,
  input  logic              rspNack,
  output seqStrobe_t        stb,
  output logic              cmdValid,
  output logic [1:0]        cmdOp,
  output logic              busy,
  output logic              done
);
  seqState_t state, nextState;
  seqState_t endState;

  assign endState = ((restartBit || !chainBit) && busHeld) ? S_STOP : S_FIN;
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);

  always_comb begin
    stb       = '0;
    cmdValid  = 1'b0;
    cmdOp     = OP_START;
    nextState = state;
    unique case (state)
      S_IDLE: if (ctrlWrEn) begin
        stb.acceptCtrl = 1'b1;
        if (ctrlWrData[BIT_HALT] && busHeld) begin
          nextState = S_STOP;
        end else if (ctrlWrData[BIT_GO]) begin
          stb.beginXfer = 1'b1;
          nextState     = busHeld ? S_DATA : S_ADDR;
        end
      end
      S_ADDR: begin
        cmdValid = 1'b1;
        cmdOp    = OP_START;
        if (rspValid) begin
          if (rspNack) begin
            stb.setErr   = 1'b1;
            stb.setAbort = 1'b1;
          end else begin
            stb.clrErr  = 1'b1;
            stb.setHeld = 1'b1;
          end
          nextState = S_DATA;
        end
      end
      S_DATA: begin
        if (errFlag) begin
          nextState = endState;
        end else begin
          cmdValid = 1'b1;
          cmdOp    = readDir ? OP_READ : OP_WRITE;
          if (rspValid) begin
            if (rspNack) begin
              stb.setErr   = 1'b1;
              stb.setAbort = 1'b1;
              nextState    = endState;
            end else begin
              stb.byteOk = 1'b1;
              if (isFinalByte) nextState = endState;
            end
          end
        end
      end
      S_STOP: begin
        cmdValid = 1'b1;
        cmdOp    = OP_STOP;
        if (rspValid) begin
          stb.clrHeld = 1'b1;
          nextState   = S_FIN;
        end
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R3
  start_only_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_START) |-> !busHeld);

  // R5
  addr_nack_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && rspValid && rspNack) |=> (errFlag && abortFlag));

  // R7
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STOP && rspValid) |=> !busHeld);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/i2cXferSeq.sv
module i2cXferSeq
  import i2cSeqPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ctrlWrEn,
  input  logic [7:0]                  ctrlWrData,
  input  logic [7:0]                  lowAddr,
  input  logic [MAX_BYTES*DATA_W-1:0] txData,
  output logic [7:0]                  ctrlRead,
  output logic [MAX_BYTES*DATA_W-1:0] rxData,
  output logic                        busy,
  output logic                        done,
  output logic [$clog2(MAX_BYTES+1)-1:0] doneCount,
  output logic                        errFlag,
  output logic                        abortFlag,
  output logic                        busHeld,
  output logic                        cmdValid,
  output logic [1:0]                  cmdOp,
  output logic [6:0]                  cmdAddr,
  output logic                        cmdRd,
  output logic [DATA_W-1:0]           cmdWrByte,
  input  logic                        rspValid,
  input  logic                        rspNack,
  input  logic [DATA_W-1:0]           rspRdByte
);
  seqStrobe_t stb;
  logic       isFinalByte;

  assign cmdAddr = lowAddr[7:1];
  assign cmdRd   = ctrlRead[BIT_RD];

  i2cSeqCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlWrEn    (ctrlWrEn),
    .ctrlWrData  (ctrlWrData),
    .busHeld     (busHeld),
    .errFlag     (errFlag),
    .abortFlag   (abortFlag),
    .isFinalByte (isFinalByte),
    .readDir     (ctrlRead[BIT_RD]),
    .chainBit    (ctrlRead[BIT_CHAIN]),
    .restartBit  (ctrlRead[BIT_RESTART]),
    .rspValid    (rspValid),
    .rspNack     (rspNack),
    .stb         (stb),
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .busy        (busy),
    .done        (done)
  );

  i2cSeqData #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busyIn      (busy),
    .ctrlWrEn    (ctrlWrEn),
    .ctrlWrData  (ctrlWrData),
    .rspRdByte   (rspRdByte),
    .txData      (txData),
    .ctrlReg     (ctrlRead),
    .rxData      (rxData),
    .xferCount   (doneCount),
    .isFinalByte (isFinalByte),
    .errFlag     (errFlag),
    .abortFlag   (abortFlag),
    .busHeld     (busHeld),
    .curTxByte   (cmdWrByte)
  );
endmodule

// File: tb/tb_i2cXferSeq.sv
module tb_i2cXferSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [7:0]  ctrlWrData = '0;
  logic [7:0]  lowAddr = '0;
  logic [31:0] txData = '0;
  logic [7:0]  ctrlRead;
  logic [31:0] rxData;
  logic        busy, done, errFlag, abortFlag, busHeld;
  logic [2:0]  doneCount;
  logic        cmdValid, cmdRd;
  logic [1:0]  cmdOp;
  logic [6:0]  cmdAddr;
  logic [7:0]  cmdWrByte;
  logic        rspValid = 1'b0;
  logic        rspNack = 1'b0;
  logic [7:0]  rspRdByte = '0;

  always #4 clk = ~clk;

  i2cXferSeq dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .lowAddr(lowAddr), .txData(txData), .ctrlRead(ctrlRead), .rxData(rxData),
    .busy(busy), .done(done), .doneCount(doneCount), .errFlag(errFlag),
    .abortFlag(abortFlag), .busHeld(busHeld), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdRd(cmdRd), .cmdWrByte(cmdWrByte),
    .rspValid(rspValid), .rspNack(rspNack), .rspRdByte(rspRdByte)
  );

  // engine model: counters written only here
  int nStart = 0, nStop = 0, dIdx = 0, waitCnt = 0;
  int lastAddr = 0, lastRd = 0;
  int wrLog [1024];
  bit nackAddrCfg = 1'b0;
  int nackAbs = -1;

  function automatic logic [7:0] rdPat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
    end else if (rspValid) begin
      rspValid <= 1'b0;
    end else if (cmdValid) begin
      if (waitCnt != 0) waitCnt <= waitCnt - 1;
      else begin
        rspValid <= 1'b1;
        rspNack  <= 1'b0;
        waitCnt  <= int'($urandom % 3);
        case (cmdOp)
          2'd0: begin
            nStart <= nStart + 1; lastAddr <= cmdAddr; lastRd <= cmdRd;
            rspNack <= nackAddrCfg;
          end
          2'd1: begin
            wrLog[dIdx % 1024] <= cmdWrByte;
            rspNack <= (dIdx == nackAbs); dIdx <= dIdx + 1;
          end
          2'd2: begin
            rspRdByte <= rdPat(dIdx);
            rspNack <= (dIdx == nackAbs); dIdx <= dIdx + 1;
          end
          default: nStop <= nStop + 1;
        endcase
      end
    end
  end

  int checks = 0, errors = 0;
  bit bHeld = 0, bErr = 0, bAbort = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one transfer or halt; nackIdx >= count means no data nack
  task automatic runXfer(input logic [7:0] ctrl, input bit nAddr,
                         input int nackIdx, input bit intrude);
    int sS, sP, sD, cnt, n, att, tmo;
    bit isHalt, doStart, xErr, xAbort, xHeld, doStop;
    logic [31:0] expRx;
    sS = nStart; sP = nStop; sD = dIdx;
    cnt = int'(ctrl[5:4]) + 1;
    isHalt = ctrl[7] && bHeld;
    n = 0; att = 0; doStart = 0; doStop = 0;
    xErr = bErr; xAbort = bAbort; xHeld = bHeld; expRx = '0;
    if (isHalt) begin
      doStop = 1; xHeld = 0;
    end else begin
      xAbort = 0;
      if (!bHeld) begin
        doStart = 1;
        if (nAddr) begin xErr = 1; xAbort = 1; end
        else begin xErr = 0; xHeld = 1; end
      end
      for (int i = 0; i < cnt; i++) begin
        if (!xErr) begin
          att++;
          if (i == nackIdx) begin xErr = 1; xAbort = 1; end
          else begin
            if (ctrl[1]) expRx[i*8 +: 8] = rdPat(sD + i);
            n++;
          end
        end
      end
      if ((ctrl[3] || !ctrl[2]) && xHeld) begin doStop = 1; xHeld = 0; end
    end
    nackAddrCfg = nAddr;
    nackAbs = sD + nackIdx;
    @(negedge clk);
    ctrlWrEn = 1; ctrlWrData = ctrl;
    @(negedge clk);
    if (intrude) begin
      ctrlWrData = ~ctrl | 8'h01;
      chk("R9 busy during sequence", int'(busy), 1);
      @(negedge clk);
    end
    ctrlWrEn = 0;
    tmo = 0;
    while (!done && tmo < 200) begin @(negedge clk); tmo++; end
    chk("R10 done seen", int'(done), 1);
    chk("R10 done count", int'(doneCount), n);
    chk("R2 readback go clear", int'(ctrlRead), int'(ctrl & 8'hFE));
    chk("R5/R6 error flag", int'(errFlag), int'(xErr));
    chk("R5/R6 aborted flag", int'(abortFlag), int'(xAbort));
    chk("R7 bus held", int'(busHeld), int'(xHeld));
    chk("R3 start count", nStart - sS, int'(doStart));
    chk("R7 R8 stop count", nStop - sP, int'(doStop));
    chk("R4 R6 data ops", dIdx - sD, att);
    if (doStart) begin
      chk("R2 address", lastAddr, int'(lowAddr[7:1]));
      chk("R3 direction", lastRd, int'(ctrl[1]));
    end
    if (!isHalt) begin
      chk("R4 rx bytes", int'(rxData), int'(expRx));
      if (!ctrl[1])
        for (int i = 0; i < att; i++)
          chk("R4 tx byte", wrLog[(sD + i) % 1024], int'(txData[i*8 +: 8]));
    end
    @(negedge clk);
    chk("R10 done single cycle", int'(done), 0);
    chk("R9 idle after done", int'(busy), 0);
    bHeld = xHeld; bErr = xErr; bAbort = xAbort;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", int'(ctrlRead), 0);
    chk("R1 err", int'(errFlag), 0);
    chk("R1 abort", int'(abortFlag), 0);
    chk("R1 held", int'(busHeld), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 cmdValid", int'(cmdValid), 0);
    rstN = 1;
    @(negedge clk);
    // R2 plain write without go: stored, no sequence
    ctrlWrEn = 1; ctrlWrData = 8'h74;
    @(negedge clk); ctrlWrEn = 0;
    chk("R2 plain write stored", int'(ctrlRead), 8'h74);
    chk("R2 plain write no busy", int'(busy), 0);
    // R4 write of 4 bytes, R2 wide bit set has no effect
    lowAddr = 8'hA5; txData = 32'h4433_2211;
    runXfer(8'h71, 0, 9, 0);
    // R5 address nack
    lowAddr = 8'h3C;
    runXfer(8'h13, 1, 9, 0);
    // R5 acked start clears error, chain holds bus, R9 intrude
    runXfer(8'h25, 0, 9, 1);
    // R3 chained continuation with no start, data nack keeps bus (R6)
    runXfer(8'h35, 0, 1, 0);
    // R6 held bus with error set: all bytes skipped
    runXfer(8'h17, 0, 9, 0);
    // R8 halt releases held bus
    runXfer(8'h80, 0, 9, 0);
    // R7 repeated start with chain forces stop
    runXfer(8'h1F, 0, 9, 0);
    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0] c;
      c = 8'($urandom) | 8'h01;
      if (($urandom % 8) != 0) c[7] = 1'b0;
      lowAddr = 8'($urandom);
      txData  = $urandom;
      runXfer(c, ($urandom % 8) == 0, int'($urandom % 8), ($urandom % 4) == 0);
    end
    summary();
  end
endmodule